// File: doc/BRIEF.md
# DRAM refresh and power-up controller

This block brings an asynchronous DRAM with an internal row counter out of power-up and keeps every row refreshed within its retention time. After reset it waits out a long start-up pause, then runs a fixed number of warm-up refresh cycles. Only after both is the host side told the memory is usable. From then on a timer produces one refresh obligation per row slot: the retention period divided by the number of rows, about 15.6 µs for either density variant. Each obligation is served by a refresh cycle in which the column strobes fall ahead of the row strobe.

The controller shares the memory pins with an access sequencer. When a refresh is owed it raises a request and waits, for as many cycles as needed, for the sequencer's grant. It then drives the row strobe, both byte column strobes and the write strobe itself. While it owns the pins the sequencer leaves the address bus at any value and keeps the data bus high-impedance.

Obligations that cannot be served because the sequencer is busy with long bursts pile up in a saturating debt counter. Once the debt passes a threshold, the controller raises a blocking flag so that the sequencer stops starting new host accesses until the refresh backlog is worked off.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: While reset is asserted, the request, ownership and ready outputs are 0, the block flag is 1, and the row, both column and write strobes are 1.
- R2: For the first PAUSE_NS/CLK_NS cycles after reset (1000 cycles in the bench), no request is raised and all strobes stay 1. The request rises in the cycle right after the pause ends.
- R3: Exactly INIT_REFRESHES (8) refresh cycles run before ready rises. Ready rises at the clock edge that ends the precharge of the last warm-up cycle and then stays 1.
- R4: A refresh cycle drives the column strobes low with the row strobe high for ceil(CSR_NS/CLK_NS) cycles (2). It then drives both low for the longer of ceil(RAS_NS/CLK_NS) and ceil(CHR_NS/CLK_NS) cycles (15). Finally it drives both high for at least the precharge time, the remainder of the random cycle time, and the row-to-column precharge time (12 cycles). Both byte column strobes are always equal.
- R5: The write strobe is 1 in every cycle, so no refresh can be taken as a write or a test mode.
- R6: The request rises one cycle after a refresh becomes owed, and stays high through the whole refresh cycle. The strobe sequence starts in the cycle after the grant is first seen high. Ownership is 1 exactly during the strobe sequence.
- R7: After the pause, one refresh obligation is added every REFI_CLKS cycles. REFI_CLKS is (16 ms / 1024) / CLK_NS for the 1K variant and (64 ms / 4096) / CLK_NS for the 4K variant (3906 at 4 ns). The first obligation is added REFI_CLKS cycles after the pause ends.
- R8: The debt saturates at DEBT_MAX (8). Each completed refresh after warm-up removes one. After a long denial of grant, exactly DEBT_MAX refresh cycles follow once grants resume.
- R9: The block flag equals the inverse of ready, ORed with a debt greater than URGENT_THRESH (4).
- R10: While debt remains, refresh cycles follow each other with exactly one cycle between the end of a precharge and the next request, plus any grant wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_gnt | input | 1 | Grant of the shared memory pins from the access sequencer; held while the request is high |
| ref_req | output | 1 | Request for the shared memory pins |
| dram_own | output | 1 | Controller is driving the strobes; address don't care, data bus high-impedance |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_lcas_n | output | 1 | Lower byte column strobe, active low |
| dram_ucas_n | output | 1 | Upper byte column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low (held high) |
| ready | output | 1 | Power-up pause and warm-up refreshes finished |
| host_block | output | 1 | Sequencer must not start a new host access |

## Verification
Every result has a fixed latency counted from a clock edge. The request follows an owed refresh by one edge, and the first strobe change follows the edge that samples the grant by one edge. Ready and the debt-driven block flag change at the edge that ends a precharge or that adds an obligation. A behavioural model in the bench advances at each rising edge using an edge count, the grant it drove and a queue of expected strobe states. Every output is compared against that model at the following falling edge, so each check samples one full register stage after its cause. Separate checks count the warm-up cycles, the cycle of the first request and the number of catch-up cycles after a long denial.

// File: rtl/dref_pkg.sv
package dref_pkg;

  typedef enum logic [2:0] {
    CYC_IDLE,
    CYC_REQ,
    CYC_CSR,
    CYC_RAS,
    CYC_PRE
  } cyc_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dref_timer.sv
module dref_timer #(
  parameter int PAUSE_CLKS = 50000,
  parameter int REFI_CLKS  = 3906
) (
  input  logic clk,
  input  logic rst_n,
  output logic pause_done,
  output logic tick
);
  localparam int SPAN = (PAUSE_CLKS > REFI_CLKS) ? PAUSE_CLKS : REFI_CLKS;
  localparam int CW   = $clog2(SPAN + 1) + 1;
  localparam logic [CW-1:0] PAUSE_LAST = CW'(PAUSE_CLKS - 1);
  localparam logic [CW-1:0] REFI_LAST  = CW'(REFI_CLKS - 1);

  logic [CW-1:0] cnt;

  assign tick = pause_done && (cnt == REFI_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      pause_done <= 1'b0;
    end else if (!pause_done) begin
      if (cnt == PAUSE_LAST) begin
        cnt        <= '0;
        pause_done <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_pause_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pause_done |=> pause_done);

  assert_tick_isolated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/dref_ledger.sv
module dref_ledger #(
  parameter int INIT_REFRESHES = 8,
  parameter int DEBT_MAX       = 8,
  parameter int URGENT_THRESH  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pause_done,
  input  logic tick,
  input  logic done,
  output logic pending,
  output logic ready,
  output logic urgent
);
  localparam int IW = $clog2(INIT_REFRESHES + 1);
  localparam int DW = $clog2(DEBT_MAX + 1);
  localparam logic [IW-1:0] INIT_LOAD = IW'(INIT_REFRESHES);
  localparam logic [DW-1:0] DEBT_TOP  = DW'(DEBT_MAX);
  localparam logic [DW-1:0] DEBT_THR  = DW'(URGENT_THRESH);

  logic [IW-1:0] init_left;
  logic [DW-1:0] debt;
  logic [DW-1:0] debt_nxt;
  logic          warm;
  logic          pay;

  assign warm = (init_left != '0);
  assign pay  = done && !warm;

  always_comb begin
    debt_nxt = debt;
    if (tick && !pay) begin
      if (debt != DEBT_TOP) debt_nxt = debt + 1'b1;
    end else if (pay && !tick) begin
      if (debt != '0) debt_nxt = debt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_left <= INIT_LOAD;
      debt      <= '0;
    end else begin
      debt <= debt_nxt;
      if (done && warm) init_left <= init_left - 1'b1;
    end
  end

  assign pending = pause_done && (warm || (debt != '0));
  assign ready   = pause_done && !warm;
  assign urgent  = (debt > DEBT_THR);

  assert_debt_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    debt <= DEBT_TOP);

  assert_ready_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  assert_done_only_owed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (warm || (debt != '0)));

endmodule

// File: rtl/dref_sequencer.sv
module dref_sequencer
  import dref_pkg::*;
#(
  parameter int CSR_CLKS = 2,
  parameter int RAS_CLKS = 15,
  parameter int RP_CLKS  = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pending,
  input  logic ref_gnt,
  output logic ref_req,
  output logic own,
  output logic ras_n,
  output logic cas_n,
  output logic done
);
  localparam int SPAN = max2(CSR_CLKS, max2(RAS_CLKS, RP_CLKS));
  localparam int CW   = $clog2(SPAN + 1) + 1;
  localparam logic [CW-1:0] CSR_LAST = CW'(CSR_CLKS - 1);
  localparam logic [CW-1:0] RAS_LAST = CW'(RAS_CLKS - 1);
  localparam logic [CW-1:0] RP_LAST  = CW'(RP_CLKS - 1);

  cyc_state_e    state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= CYC_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        CYC_IDLE: if (pending) state <= CYC_REQ;
        CYC_REQ: begin
          cnt <= '0;
          if (ref_gnt) state <= CYC_CSR;
        end
        CYC_CSR: begin
          if (cnt == CSR_LAST) begin
            cnt   <= '0;
            state <= CYC_RAS;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        CYC_RAS: begin
          if (cnt == RAS_LAST) begin
            cnt   <= '0;
            state <= CYC_PRE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        CYC_PRE: begin
          if (cnt == RP_LAST) begin
            cnt   <= '0;
            state <= CYC_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= CYC_IDLE;
      endcase
    end
  end

  assign ref_req = (state != CYC_IDLE);
  assign own     = (state == CYC_CSR) || (state == CYC_RAS) || (state == CYC_PRE);
  assign ras_n   = (state != CYC_RAS);
  assign cas_n   = !((state == CYC_CSR) || (state == CYC_RAS));
  assign done    = (state == CYC_PRE) && (cnt == RP_LAST);

  assert_wait_for_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CYC_REQ && !ref_gnt) |=> (state == CYC_REQ));

  assert_start_on_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CYC_REQ && ref_gnt) |=> (own && !cas_n && ras_n));

endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
  import dref_pkg::*;
#(
  parameter int CLK_NS         = 4,
  parameter int PAUSE_NS       = 200000,
  parameter bit FOUR_K         = 1'b0,
  parameter int INIT_REFRESHES = 8,
  parameter int DEBT_MAX       = 8,
  parameter int URGENT_THRESH  = 4,
  parameter int CSR_NS         = 5,
  parameter int CHR_NS         = 10,
  parameter int RAS_NS         = 60,
  parameter int RP_NS          = 40,
  parameter int RC_NS          = 105,
  parameter int RPC_NS         = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_gnt,
  output logic ref_req,
  output logic dram_own,
  output logic dram_ras_n,
  output logic dram_lcas_n,
  output logic dram_ucas_n,
  output logic dram_we_n,
  output logic ready,
  output logic host_block
);
  localparam int RET_MS     = FOUR_K ? 64 : 16;
  localparam int ROWS       = FOUR_K ? 4096 : 1024;
  localparam int PAUSE_CLKS = max2(1, ceil_div(PAUSE_NS, CLK_NS));
  localparam int REFI_CLKS  = max2(2, (RET_MS * 1000000) / (ROWS * CLK_NS));
  localparam int CSR_CLKS   = max2(1, ceil_div(CSR_NS, CLK_NS));
  localparam int RAS_CLKS   = max2(1, max2(ceil_div(RAS_NS, CLK_NS), ceil_div(CHR_NS, CLK_NS)));
  localparam int RC_REST_NS = max2(0, RC_NS - RAS_CLKS * CLK_NS);
  localparam int RP_CLKS    = max2(1, max2(ceil_div(RP_NS, CLK_NS),
                                      max2(ceil_div(RC_REST_NS, CLK_NS), ceil_div(RPC_NS, CLK_NS))));

  logic pause_done;
  logic tick;
  logic done;
  logic pending;
  logic urgent;
  logic cas_n;

  dref_timer #(
    .PAUSE_CLKS(PAUSE_CLKS),
    .REFI_CLKS (REFI_CLKS)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .pause_done(pause_done),
    .tick      (tick)
  );

  dref_ledger #(
    .INIT_REFRESHES(INIT_REFRESHES),
    .DEBT_MAX      (DEBT_MAX),
    .URGENT_THRESH (URGENT_THRESH)
  ) u_ledger (
    .clk       (clk),
    .rst_n     (rst_n),
    .pause_done(pause_done),
    .tick      (tick),
    .done      (done),
    .pending   (pending),
    .ready     (ready),
    .urgent    (urgent)
  );

  dref_sequencer #(
    .CSR_CLKS(CSR_CLKS),
    .RAS_CLKS(RAS_CLKS),
    .RP_CLKS (RP_CLKS)
  ) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .pending(pending),
    .ref_gnt(ref_gnt),
    .ref_req(ref_req),
    .own    (dram_own),
    .ras_n  (dram_ras_n),
    .cas_n  (cas_n),
    .done   (done)
  );

  assign dram_lcas_n = cas_n;
  assign dram_ucas_n = cas_n;
  assign dram_we_n   = 1'b1;
  assign host_block  = !ready || urgent;

  // Strobe run-length counters used only by the assertions below.
  localparam int RUN_W = $clog2(CSR_CLKS + RAS_CLKS + RP_CLKS + 4) + 1;
  logic [RUN_W-1:0] low_run;
  logic [RUN_W-1:0] high_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run  <= '0;
      high_run <= '1;
    end else if (!dram_ras_n) begin
      high_run <= '0;
      if (low_run != '1) low_run <= low_run + 1'b1;
    end else begin
      low_run <= '0;
      if (high_run != '1) high_run <= high_run + 1'b1;
    end
  end

  assert_quiet_pause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pause_done |-> (dram_ras_n && dram_lcas_n && !ref_req));

  assert_cas_before_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> ($past(!dram_lcas_n) && !dram_lcas_n));

  assert_cas_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_lcas_n) |-> $past(!dram_ras_n));

  assert_ras_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_ras_n) |-> (low_run >= RUN_W'(RAS_CLKS)));

  assert_precharge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> (high_run >= RUN_W'(RP_CLKS + CSR_CLKS)));

  assert_own_inside_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dram_own |-> ref_req);

  assert_req_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ref_req) |-> $past(dram_own));

endmodule

// File: tb/tb_dram_refresh_ctrl.sv
`timescale 1ns/1ps
module tb_dram_refresh_ctrl;
  localparam int PAUSE = 1000;
  localparam int REFI  = 3906;
  localparam int CSR   = 2;
  localparam int RASC  = 15;
  localparam int RP    = 12;
  localparam int INIT  = 8;
  localparam int DMAX  = 8;
  localparam int THR   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_gnt = 1'b0;
  logic ref_req, dram_own, dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n;
  logic ready, host_block;

  always #2 clk = ~clk;

  dram_refresh_ctrl #(.PAUSE_NS(4000)) dut (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
    .dram_own(dram_own), .dram_ras_n(dram_ras_n), .dram_lcas_n(dram_lcas_n),
    .dram_ucas_n(dram_ucas_n), .dram_we_n(dram_we_n), .ready(ready),
    .host_block(host_block)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Grant policy of the emulated access sequencer
  bit allow_gnt = 1'b1;
  int gnt_delay = 3;
  int req_wait = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      req_wait = 0;
      ref_gnt  = 1'b0;
    end else begin
      if (ref_req) req_wait = req_wait + 1; else req_wait = 0;
      ref_gnt = allow_gnt && ref_req && (req_wait > gnt_delay);
    end
  end

  // Behavioural reference: edge count, debt, warm-up left, expected strobe queue
  // Queue entry: bit0 row strobe, bit1 column strobe, bit2 last precharge cycle
  int e = 0;
  int md = 0;
  int mi = INIT;
  int mmode = 0;
  int cur = 3;
  int q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      e = 0; md = 0; mi = INIT; mmode = 0; cur = 3; q.delete();
    end else begin
      bit pd_b, tk, dn, pend, pay;
      int d;
      pd_b = (e >= PAUSE);
      e = e + 1;
      tk   = (e > PAUSE) && (((e - PAUSE) % REFI) == 0);
      pend = pd_b && (mi > 0 || md > 0);
      dn   = (mmode == 2) && cur[2];
      pay  = dn && (mi == 0);
      d = md + (tk ? 1 : 0) - (pay ? 1 : 0);
      if (d > DMAX) d = DMAX;
      if (d < 0) d = 0;
      md = d;
      if (dn && mi > 0) mi = mi - 1;
      case (mmode)
        0: if (pend) mmode = 1;
        1: if (ref_gnt) begin
             mmode = 2;
             cur = 1;
             for (int i = 1; i < CSR; i++) q.push_back(1);
             for (int i = 0; i < RASC; i++) q.push_back(0);
             for (int i = 1; i < RP; i++) q.push_back(3);
             q.push_back(7);
           end
        default: if (cur[2]) begin
                   mmode = 0;
                   cur = 3;
                 end else begin
                   cur = q.pop_front();
                 end
      endcase
    end
  end

  // Per-cycle comparison, away from the active edge
  int falls = 0;
  int first_req = -1;
  logic prev_ras = 1'b1;
  always @(negedge clk) begin
    int exp_ready;
    exp_ready = ((e >= PAUSE) && (mi == 0)) ? 1 : 0;
    chk("R5", "we_n", int'(dram_we_n), 1);
    chk("R4", "ucas_n vs lcas_n", int'(dram_ucas_n), int'(dram_lcas_n));
    chk("R4", "ras_n", int'(dram_ras_n), cur & 1);
    chk("R4", "lcas_n", int'(dram_lcas_n), (cur >> 1) & 1);
    chk("R6", "ref_req", int'(ref_req), (mmode != 0) ? 1 : 0);
    chk("R6", "dram_own", int'(dram_own), (mmode == 2) ? 1 : 0);
    chk("R3", "ready", int'(ready), exp_ready);
    chk("R9", "host_block", int'(host_block), (exp_ready == 0 || md > THR) ? 1 : 0);
    if (prev_ras && !dram_ras_n) falls++;
    prev_ras = dram_ras_n;
    if (ref_req && first_req < 0) first_req = e;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    finish_run();
  end

  initial begin
    int f0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "reset ref_req", int'(ref_req), 0);
    chk("R1", "reset dram_own", int'(dram_own), 0);
    chk("R1", "reset ras_n", int'(dram_ras_n), 1);
    chk("R1", "reset lcas_n", int'(dram_lcas_n), 1);
    chk("R1", "reset ucas_n", int'(dram_ucas_n), 1);
    chk("R1", "reset we_n", int'(dram_we_n), 1);
    chk("R1", "reset ready", int'(ready), 0);
    chk("R1", "reset host_block", int'(host_block), 1);
    rst_n = 1'b1;

    // R2 / R3: pause then warm-up with a 3-cycle grant delay
    while (!ready) @(negedge clk);
    chk("R2", "first request cycle", first_req, PAUSE + 1);
    chk("R3", "warm-up cycles before ready", falls, INIT);

    // R7 / R10: periodic refresh with immediate grant
    gnt_delay = 0;
    repeat (2 * REFI) @(negedge clk);

    // R8 / R9: deny grants long enough for the debt to saturate
    while (ref_req) @(negedge clk);
    allow_gnt = 1'b0;
    repeat (10 * REFI) @(negedge clk);
    chk("R9", "host_block under saturated debt", int'(host_block), 1);
    chk("R6", "request held while denied", int'(ref_req), 1);
    while (((e - PAUSE) % REFI) != 10) @(negedge clk);
    allow_gnt = 1'b1;
    gnt_delay = 1;
    f0 = falls;
    repeat (300) @(negedge clk);
    chk("R8", "catch-up cycles after denial", falls - f0, DMAX);
    chk("R9", "host_block after catch-up", int'(host_block), 0);

    // R7: periodic refresh with a slow grant
    gnt_delay = 7;
    f0 = falls;
    repeat (2 * REFI) @(negedge clk);
    chk("R7", "refreshes in two intervals", falls - f0, 2);
    finish_run();
  end

endmodule